// File: doc/BRIEF.md
# Pre-Adder Multiply-Accumulate Slice

This block is a behavioural multiply-accumulate datapath with a pre-adder in front of the multiplier. Two coefficient registers share one coefficient input. Two A-operand registers share one A input. A D-operand register sits beside them. Each register loads under its own enable, and a per-cycle select picks which bank member enters the pipeline.

The pre-adder forms zero, A, +D, -D, A+D or A-D. Its result is registered together with the selected coefficient. The next stage registers the signed product. The last stage either loads the product into the 48-bit output register or adds it to the value already there, and it can negate the product first.

The pipeline runs from the operand registers to the pre-adder register, then the product register, then the output register. With every enable held high, a value loaded into an operand register reaches the output four clocks later. A synchronous, active-high reset clears every register to zero.

Top module: `mac_preadd_slice`

## Requirements
- R1: A clock edge with `rst` high clears every register. `p_out` reads zero in the cycle after that edge.
- R2: `b1_ce` loads `b_in` into coefficient register 1, and `b2_ce` loads it into coefficient register 2. At an edge where `ad_ce` is high, the coefficient that moves forward is register 1 when `b_sel` is 0 and register 2 when `b_sel` is 1.
- R3: `a1_ce` loads `a_in` into A register 1, and `a2_ce` loads it into A register 2. At an edge where `ad_ce` is high, `a_sel` picks register 1 when 0 and register 2 when 1.
- R4: `d_ce` loads `d_in` into the D register. While `d_ce` is low, the D register keeps its value whatever `d_in` does.
- R5: At an edge where `ad_ce` is high, the pre-adder register takes a value set by `use_a`, `use_d` and `d_sub`.
  - The A term is the selected A when `use_a` is 1, else 0.
  - The D term is D when `use_d` is 1, else 0.
  - The result is (A term - D term) when `d_sub` is 1, else (A term + D term).
  - The result wraps to 25 bits, so 16777215 + 1 gives -16777216.
- R6: While `ad_ce` is low, the pre-adder register and the coefficient that travels with it hold their values.
- R7: At an edge where `m_ce` is high, the product register takes the 43-bit signed product of the pre-adder register and its coefficient. While `m_ce` is low, it holds.
- R8: When `prod_neg` is 1 at an output-enabled edge, the sign-extended product is negated before the output stage uses it.
- R9: At an edge where `p_ce` is high, the output register takes the product term when `acc_en` is 0. When `acc_en` is 1, it takes its old value plus the product term, wrapped to 48 bits.
- R10: While `p_ce` is low, `p_out` holds its value.
- R11: With all enables high, a product loaded through the operand registers at one edge appears on `p_out` after the fourth edge, counting that one, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| b_in | input | 18 | Signed coefficient input |
| b1_ce | input | 1 | Load coefficient register 1 |
| b2_ce | input | 1 | Load coefficient register 2 |
| b_sel | input | 1 | Coefficient select (0: register 1, 1: register 2) |
| a_in | input | 25 | Signed A operand input |
| a1_ce | input | 1 | Load A register 1 |
| a2_ce | input | 1 | Load A register 2 |
| a_sel | input | 1 | A select (0: register 1, 1: register 2) |
| d_in | input | 25 | Signed D operand input |
| d_ce | input | 1 | Load D register |
| ad_ce | input | 1 | Load pre-adder register and its coefficient |
| use_a | input | 1 | Include A term in pre-adder |
| use_d | input | 1 | Include D term in pre-adder |
| d_sub | input | 1 | Subtract D term instead of adding it |
| m_ce | input | 1 | Load product register |
| prod_neg | input | 1 | Negate product at the output stage |
| acc_en | input | 1 | Add product to output register instead of loading it |
| p_ce | input | 1 | Load output register |
| p_out | output | 48 | Signed accumulator / output |

## Verification
The assertions check the last three stages on every cycle. They confirm that the product register equals the product of the previous pre-adder value and its coefficient. They confirm that the output register loads, negates or accumulates that product as `acc_en` and `prod_neg` direct, and that reset clears it. They also confirm that the D, pre-adder and output registers hold whenever their enables are low.

The bench's scenarios are needed for the parts no property sees end to end:
- the bank selects, where a wrong register member leaves the arithmetic internally consistent;
- the pre-adder mode table and its 25-bit wrap;
- the exact four-clock latency;
- accumulation chains longer than eight cycles.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;
  // Pre-adder mode controls, sampled together at the pre-adder stage.
  typedef struct packed {
    logic use_a;
    logic use_d;
    logic d_sub;
  } pre_ctl_t;
endpackage

// File: rtl/mac_opnd_bank.sv
module mac_opnd_bank #(
  parameter int W = 25
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] din,
  input  logic                ce1,
  input  logic                ce2,
  input  logic                sel,
  output logic signed [W-1:0] q_sel
);
  localparam int NREG = 2;
  logic signed [W-1:0] bank_q [NREG];
  logic [NREG-1:0]     ce_v;

  assign ce_v = {ce2, ce1};

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)          bank_q[i] <= '0;
      else if (ce_v[i]) bank_q[i] <= din;
    end
  end

  assign q_sel = sel ? bank_q[1] : bank_q[0];
endmodule

// File: rtl/mac_preadder.sv
module mac_preadder
  import mac_slice_pkg::*;
#(
  parameter int A_W = 25,
  parameter int B_W = 18
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic signed [A_W-1:0] a_val,
  input  logic signed [B_W-1:0] b_val,
  input  logic signed [A_W-1:0] d_in,
  input  logic                  d_ce,
  input  logic                  ad_ce,
  input  pre_ctl_t              ctl,
  output logic signed [A_W-1:0] d_q,
  output logic signed [A_W-1:0] ad_q,
  output logic signed [B_W-1:0] bs_q
);
  // Pre-adder arithmetic; result wraps to A_W bits.
  function automatic logic signed [A_W-1:0] f_preadd(
    input logic signed [A_W-1:0] a,
    input logic signed [A_W-1:0] d,
    input pre_ctl_t              c
  );
    logic signed [A_W-1:0] at, dt;
    at = c.use_a ? a : '0;
    dt = c.use_d ? d : '0;
    return c.d_sub ? (at - dt) : (at + dt);
  endfunction

  logic signed [A_W-1:0] pre_sum;
  assign pre_sum = f_preadd(a_val, d_q, ctl);

  always_ff @(posedge clk) begin
    if (rst)       d_q <= '0;
    else if (d_ce) d_q <= d_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_q <= '0;
      bs_q <= '0;
    end else if (ad_ce) begin
      ad_q <= pre_sum;
      bs_q <= b_val;
    end
  end
endmodule

// File: rtl/mac_mul_acc.sv
module mac_mul_acc #(
  parameter int A_W = 25,
  parameter int B_W = 18,
  parameter int P_W = 48
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic signed [A_W-1:0]     ad,
  input  logic signed [B_W-1:0]     bs,
  input  logic                      m_ce,
  input  logic                      p_ce,
  input  logic                      neg,
  input  logic                      acc,
  output logic signed [A_W+B_W-1:0] m_q,
  output logic signed [P_W-1:0]     p_q
);
  localparam int M_W = A_W + B_W;

  // Signed full-width product of the two pipeline operands.
  function automatic logic signed [M_W-1:0] f_mul(
    input logic signed [A_W-1:0] x,
    input logic signed [B_W-1:0] y
  );
    logic signed [M_W-1:0] xe, ye;
    xe = {{B_W{x[A_W-1]}}, x};
    ye = {{A_W{y[B_W-1]}}, y};
    return xe * ye;
  endfunction

  // Output stage: sign-extend, optional negate, load or accumulate.
  function automatic logic signed [P_W-1:0] f_acc(
    input logic signed [P_W-1:0] p,
    input logic signed [M_W-1:0] m,
    input logic                  n,
    input logic                  a
  );
    logic signed [P_W-1:0] ext, term;
    ext  = {{(P_W-M_W){m[M_W-1]}}, m};
    term = n ? -ext : ext;
    return a ? (p + term) : term;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       m_q <= '0;
    else if (m_ce) m_q <= f_mul(ad, bs);
  end

  always_ff @(posedge clk) begin
    if (rst)       p_q <= '0;
    else if (p_ce) p_q <= f_acc(p_q, m_q, neg, acc);
  end
endmodule

// File: rtl/mac_preadd_slice.sv
module mac_preadd_slice
  import mac_slice_pkg::*;
#(
  parameter int A_W = 25,
  parameter int B_W = 18,
  parameter int P_W = 48
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [B_W-1:0] b_in,
  input  logic           b1_ce,
  input  logic           b2_ce,
  input  logic           b_sel,
  input  logic [A_W-1:0] a_in,
  input  logic           a1_ce,
  input  logic           a2_ce,
  input  logic           a_sel,
  input  logic [A_W-1:0] d_in,
  input  logic           d_ce,
  input  logic           ad_ce,
  input  logic           use_a,
  input  logic           use_d,
  input  logic           d_sub,
  input  logic           m_ce,
  input  logic           prod_neg,
  input  logic           acc_en,
  input  logic           p_ce,
  output logic [P_W-1:0] p_out
);
  localparam int M_W = A_W + B_W;

  logic signed [B_W-1:0] b_val;
  logic signed [A_W-1:0] a_val;
  logic signed [A_W-1:0] d_q;
  logic signed [A_W-1:0] ad_q;
  logic signed [B_W-1:0] bs_q;
  logic signed [M_W-1:0] m_q;
  logic signed [P_W-1:0] p_q;
  pre_ctl_t              pre_ctl;

  assign pre_ctl = '{use_a: use_a, use_d: use_d, d_sub: d_sub};

  mac_opnd_bank #(.W(B_W)) u_bbank (
    .clk(clk), .rst(rst), .din(b_in), .ce1(b1_ce), .ce2(b2_ce),
    .sel(b_sel), .q_sel(b_val)
  );

  mac_opnd_bank #(.W(A_W)) u_abank (
    .clk(clk), .rst(rst), .din(a_in), .ce1(a1_ce), .ce2(a2_ce),
    .sel(a_sel), .q_sel(a_val)
  );

  mac_preadder #(.A_W(A_W), .B_W(B_W)) u_pre (
    .clk(clk), .rst(rst), .a_val(a_val), .b_val(b_val), .d_in(d_in),
    .d_ce(d_ce), .ad_ce(ad_ce), .ctl(pre_ctl), .d_q(d_q), .ad_q(ad_q),
    .bs_q(bs_q)
  );

  mac_mul_acc #(.A_W(A_W), .B_W(B_W), .P_W(P_W)) u_mac (
    .clk(clk), .rst(rst), .ad(ad_q), .bs(bs_q), .m_ce(m_ce), .p_ce(p_ce),
    .neg(prod_neg), .acc(acc_en), .m_q(m_q), .p_q(p_q)
  );

  assign p_out = p_q;
endmodule

// File: rtl/mac_preadd_slice_chk.sv
module mac_preadd_slice_chk #(
  parameter int A_W = 25,
  parameter int B_W = 18,
  parameter int P_W = 48
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      d_ce,
  input logic                      ad_ce,
  input logic                      m_ce,
  input logic                      p_ce,
  input logic                      acc_en,
  input logic                      prod_neg,
  input logic signed [A_W-1:0]     d_q,
  input logic signed [A_W-1:0]     ad_q,
  input logic signed [B_W-1:0]     bs_q,
  input logic signed [A_W+B_W-1:0] m_q,
  input logic signed [P_W-1:0]     p_out
);
  localparam int M_W = A_W + B_W;

  logic signed [P_W-1:0] m_ext;
  logic signed [M_W-1:0] ad_ext, bs_ext;
  assign m_ext  = {{(P_W-M_W){m_q[M_W-1]}}, m_q};
  assign ad_ext = {{B_W{ad_q[A_W-1]}}, ad_q};
  assign bs_ext = {{A_W{bs_q[B_W-1]}}, bs_q};

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (p_out == '0));

  assert_d_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !d_ce |=> $stable(d_q));

  assert_pre_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !ad_ce |=> ($stable(ad_q) && $stable(bs_q)));

  assert_product_R7: assert property (@(posedge clk) disable iff (rst)
    m_ce |=> (m_q == ($past(ad_ext) * $past(bs_ext))));

  assert_negate_R8: assert property (@(posedge clk) disable iff (rst)
    (p_ce && !acc_en && prod_neg) |=> (p_out == -$past(m_ext)));

  assert_load_R9: assert property (@(posedge clk) disable iff (rst)
    (p_ce && !acc_en && !prod_neg) |=> (p_out == $past(m_ext)));

  assert_accum_R9: assert property (@(posedge clk) disable iff (rst)
    (p_ce && acc_en && !prod_neg) |=> (p_out == $past(p_out) + $past(m_ext)));

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !p_ce |=> $stable(p_out));
endmodule

bind mac_preadd_slice mac_preadd_slice_chk #(.A_W(A_W), .B_W(B_W), .P_W(P_W)) u_chk (
  .clk(clk), .rst(rst), .d_ce(d_ce), .ad_ce(ad_ce), .m_ce(m_ce), .p_ce(p_ce),
  .acc_en(acc_en), .prod_neg(prod_neg), .d_q(d_q), .ad_q(ad_q), .bs_q(bs_q),
  .m_q(m_q), .p_out(p_q)
);

// File: tb/mac_preadd_slice_bench.sv
module mac_preadd_slice_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [17:0] b_in = '0;
  logic [24:0] a_in = '0, d_in = '0;
  logic b1_ce = 0, b2_ce = 0, b_sel = 0, a1_ce = 0, a2_ce = 0, a_sel = 0;
  logic d_ce = 0, ad_ce = 0, use_a = 0, use_d = 0, d_sub = 0;
  logic m_ce = 0, prod_neg = 0, acc_en = 0, p_ce = 0;
  logic [47:0] p_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  longint rb1, rb2, ra1, ra2, rd, rad, rbs, rm, rp;

  always #10 clk = ~clk;

  mac_preadd_slice u_mac_preadd_slice (
    .clk(clk), .rst(rst), .b_in(b_in), .b1_ce(b1_ce), .b2_ce(b2_ce),
    .b_sel(b_sel), .a_in(a_in), .a1_ce(a1_ce), .a2_ce(a2_ce), .a_sel(a_sel),
    .d_in(d_in), .d_ce(d_ce), .ad_ce(ad_ce), .use_a(use_a), .use_d(use_d),
    .d_sub(d_sub), .m_ce(m_ce), .prod_neg(prod_neg), .acc_en(acc_en),
    .p_ce(p_ce), .p_out(p_out)
  );

  function automatic longint wrapw(longint v, int w);
    return (v <<< (64 - w)) >>> (64 - w);
  endfunction

  function automatic longint sx(longint v, int w);
    return wrapw(v, w);
  endfunction

  task automatic model_step();
    longint nb1, nb2, na1, na2, nd, nad, nbs, nm, np, at, dt;
    if (rst) begin
      rb1 = 0; rb2 = 0; ra1 = 0; ra2 = 0; rd = 0;
      rad = 0; rbs = 0; rm = 0; rp = 0;
      return;
    end
    nb1 = b1_ce ? sx(longint'(b_in), 18) : rb1;
    nb2 = b2_ce ? sx(longint'(b_in), 18) : rb2;
    na1 = a1_ce ? sx(longint'(a_in), 25) : ra1;
    na2 = a2_ce ? sx(longint'(a_in), 25) : ra2;
    nd  = d_ce  ? sx(longint'(d_in), 25) : rd;
    at  = use_a ? (a_sel ? ra2 : ra1) : 0;
    dt  = use_d ? rd : 0;
    nad = ad_ce ? wrapw(d_sub ? at - dt : at + dt, 25) : rad;
    nbs = ad_ce ? (b_sel ? rb2 : rb1) : rbs;
    nm  = m_ce  ? rad * rbs : rm;
    np  = p_ce  ? wrapw((acc_en ? rp : 0) + (prod_neg ? -rm : rm), 48) : rp;
    rb1 = nb1; rb2 = nb2; ra1 = na1; ra2 = na2; rd = nd;
    rad = nad; rbs = nbs; rm = nm; rp = np;
  endtask

  task automatic chk(longint exp_v, string req);
    longint act;
    act = sx(longint'(p_out), 48);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: p_out actual %0d expected %0d at %0t", req, act, exp_v, $time);
    end
  endtask

  // one clock: model follows the edge, comparison away from it
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(rp, cur_req);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    ticks(3);
    rst = 0;
    tick();
    chk(0, "R1");

    // R11: four-clock latency
    cur_req = "R11";
    a_in = 25'd3; b_in = 18'd5; a1_ce = 1; b1_ce = 1;
    use_a = 1; ad_ce = 1; m_ce = 1; p_ce = 1;
    tick();
    a1_ce = 0; b1_ce = 0;
    ticks(2);
    chk(0, "R11");
    tick();
    chk(15, "R11");

    // R5: all mode combinations with fresh operands
    cur_req = "R5";
    for (int m = 0; m < 8; m++) begin
      {use_a, use_d, d_sub} = 3'(m);
      a_in = 25'($urandom); d_in = 25'($urandom); b_in = 18'($urandom);
      a1_ce = 1; d_ce = 1; b1_ce = 1;
      ticks(5);
    end
    // R5: 25-bit wrap of A + D
    a_in = 25'h0FF_FFFF; d_in = 25'd1; b_in = 18'd1;
    use_a = 1; use_d = 1; d_sub = 0;
    ticks(4);
    chk(-16777216, "R5");
    a1_ce = 0; d_ce = 0; b1_ce = 0;

    // R2 / R3: bank loading and selects
    cur_req = "R3";
    use_d = 0;
    a_in = 25'd11; a1_ce = 1; b_in = 18'd3; b1_ce = 1; tick();
    a1_ce = 0; b1_ce = 0;
    a_in = -25'sd7; a2_ce = 1; b_in = 18'd100; b2_ce = 1; tick();
    a2_ce = 0; b2_ce = 0;
    a_sel = 0; b_sel = 0; ticks(3); chk(33, "R2");
    a_sel = 0; b_sel = 1; ticks(3); chk(1100, "R2");
    a_sel = 1; b_sel = 0; ticks(3); chk(-21, "R3");
    a_sel = 1; b_sel = 1; ticks(3); chk(-700, "R3");

    // R8: negation
    cur_req = "R8";
    prod_neg = 1; ticks(3); chk(700, "R8");
    prod_neg = 0;

    // R9: accumulation chain of twelve
    cur_req = "R9";
    a_sel = 0; b_sel = 0; ticks(3); chk(33, "R9");
    acc_en = 1; ticks(12); chk(429, "R9");

    // R10: output hold
    cur_req = "R10";
    p_ce = 0; acc_en = 0; a_sel = 1;
    ticks(5); chk(429, "R10");

    // R6: pre-adder hold (holds -7 * 3)
    cur_req = "R6";
    p_ce = 1; ad_ce = 0; a_sel = 0;
    ticks(3); chk(-21, "R6");

    // R4: D hold (D stays 1 from wrap test)
    cur_req = "R4";
    ad_ce = 1; use_a = 0; use_d = 1; d_in = 25'd999;
    ticks(3); chk(3, "R4");

    // R7: product hold
    cur_req = "R7";
    m_ce = 0; use_a = 1; use_d = 0; a_sel = 1;
    ticks(4); chk(3, "R7");
    m_ce = 1;

    // R1: reset mid-run
    cur_req = "R1";
    rst = 1; tick();
    rst = 0; chk(0, "R1");

    // random traffic: every control and operand varies
    cur_req = "R9";
    for (int i = 0; i < 800; i++) begin
      rst = ($urandom % 97) == 0;
      b_in = 18'($urandom); a_in = 25'($urandom); d_in = 25'($urandom);
      {b1_ce, b2_ce, b_sel, a1_ce, a2_ce, a_sel, d_ce} = 7'($urandom);
      {use_a, use_d, d_sub, prod_neg, acc_en} = 5'($urandom);
      ad_ce = ($urandom % 4) != 0;
      m_ce  = ($urandom % 4) != 0;
      p_ce  = ($urandom % 4) != 0;
      tick();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule